// File: doc/BRIEF.md
# Watchdog Timer with Reset Request

The block is a free-running watchdog counter that supervises a processor. The counter advances on every clock. If software does not restart it before it reaches one of four selectable intervals, the block sets a sticky timeout flag. If software has also armed the reset function, the timeout raises a reset request for the processor. That request is a pulse of fixed length. After the pulse the counter starts again from zero.

Software keeps the system alive by issuing a restart strobe at regular intervals. The restart strobe and the arm bit are protected. A write to either one is accepted only while the unlock input is high. In the full system that input is the output of an unlock sequence. The timeout flag is cleared by its own strobe, which needs no unlock. Changing the interval select restarts the count from zero. A switch to a shorter interval therefore cannot expire at once.

Top module: `wdt_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `expired_o`, `cpu_rst_o` and `arm_o` are 0 and the count is zero.
- R2: The interval select `ivl_sel_i` value k (0 to 3) sets a timeout of 2^(EXP_BASE + k*EXP_STEP) clocks. Select 0 is the shortest and 3 is the longest. With the defaults the intervals are 2^17, 2^20, 2^23 and 2^26 clocks.
- R3: When the count reaches the selected interval, `expired_o` is set on that clock edge and stays set. The counter wraps to zero and keeps running.
- R4: A restart (`kick_i` high while `unlock_i` is high) clears the count, so the next timeout comes one full interval after that edge. A restart does not clear `expired_o`. A restart that lands on the last cycle of an interval prevents that timeout.
- R5: `kick_i` while `unlock_i` is low has no effect on the count.
- R6: The arm bit `arm_o` takes the value of `arm_d_i` only on an edge where `arm_we_i` and `unlock_i` are both high. Otherwise it holds.
- R7: A timeout while `arm_o` is 1 drives `cpu_rst_o` high for exactly PULSE_LEN (default 4) clocks, starting on the timeout edge. A timeout while `arm_o` is 0 never raises `cpu_rst_o`.
- R8: The count is held at zero while `cpu_rst_o` is high and resumes from zero after the pulse. The next timeout therefore follows the end of the pulse by one full interval.
- R9: Any change of `ivl_sel_i` clears the count on the edge where the change is seen. The new interval is timed from that edge.
- R10: `flag_clr_i` clears `expired_o` on the next edge. If a timeout occurs on the same edge, the timeout wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ivl_sel_i | input | 2 | Timeout interval select (0 shortest, 3 longest) |
| kick_i | input | 1 | Restart strobe (protected) |
| arm_we_i | input | 1 | Write strobe for the arm bit (protected) |
| arm_d_i | input | 1 | Value written to the arm bit |
| unlock_i | input | 1 | Write permit for the protected controls |
| flag_clr_i | input | 1 | Clear strobe for the timeout flag |
| arm_o | output | 1 | Current arm bit; 1 lets a timeout request a reset |
| expired_o | output | 1 | Sticky timeout flag |
| cpu_rst_o | output | 1 | Reset request pulse to the processor |

## Verification
The hardest cases to reach from the ports are the edges where two events coincide. One is a restart that arrives on exactly the last cycle of an interval, which must cancel the timeout. The other is a flag clear on the same edge as a timeout, where the timeout must win. The bench scales the intervals down to 16 to 128 clocks and counts clock edges from the release of reset. It then places the strobe on the precise cycle computed from R2. It also follows the arm bit, the reset pulse and the held count over two full intervals. This shows that the second timeout comes one interval after the pulse ends.

// File: rtl/wdt_pkg.sv
// Package: shared types and constants for the watchdog block.
// Assumes: exactly four selectable intervals.
package wdt_pkg;
    localparam int NUM_SEL = 4;
    localparam int SEL_W   = 2;
    typedef logic [SEL_W-1:0] wdt_sel_t;
endpackage

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Counts clocks and raises tick_o for one cycle when the count reaches the
// selected interval. Clears on a qualified restart, on a change of the
// interval select, and while hold_i is high.
// Assumes: restart_i is already qualified by the write permit; EXP_BASE >= 1.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int EXP_BASE = 17,
    parameter int EXP_STEP = 3,
    parameter int CNT_W    = EXP_BASE + (NUM_SEL - 1) * EXP_STEP
) (
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_sel_t sel_i,
    input  logic     restart_i,
    input  logic     hold_i,
    output logic     tick_o
);
    localparam int LW = CNT_W + 1;

    logic [CNT_W-1:0] lim_tbl [NUM_SEL];
    logic [CNT_W-1:0] cnt_q;
    wdt_sel_t         sel_q;
    logic             sel_chg;
    logic             terminal;
    logic             clear;

    // Build the terminal count for each interval select.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
        localparam int            EXPN = EXP_BASE + g * EXP_STEP;
        localparam logic [LW-1:0] FULL = LW'(1) << EXPN;
        assign lim_tbl[g] = CNT_W'(FULL - LW'(1));
    end

    // Decode the events that act on the count this cycle.
    always_comb begin
        sel_chg  = (sel_i != sel_q);
        terminal = (cnt_q == lim_tbl[sel_q]);
        clear    = sel_chg || restart_i || hold_i;
        tick_o   = terminal && !clear;
    end

    // Advance, wrap or clear the count; track the applied select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= sel_i;
            if (clear || terminal) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (cnt_q == '0));
    // R4
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
    // R8
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (cnt_q == '0));
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_tbl[sel_q]);
endmodule

// File: rtl/wdt_ctrl.sv
// Module: wdt_ctrl
// Holds the protected arm bit, qualifies the restart strobe with the write
// permit, and keeps the sticky timeout flag.
// Assumes: tick_i is a single-cycle timeout event from the counter.
module wdt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_i,
    input  logic kick_i,
    input  logic arm_we_i,
    input  logic arm_d_i,
    input  logic flag_clr_i,
    input  logic tick_i,
    output logic restart_o,
    output logic arm_o,
    output logic flag_o
);
    logic arm_q;
    logic flag_q;

    // Pass a restart only while writes are permitted.
    always_comb restart_o = kick_i && unlock_i;

    // Update the arm bit on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    arm_q <= 1'b0;
        else if (arm_we_i && unlock_i) arm_q <= arm_d_i;
    end

    // Set the flag on a timeout, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (tick_i)     flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    assign arm_o  = arm_q;
    assign flag_o = flag_q;

    // R6
    arm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_we_i && unlock_i) |=> $stable(arm_q));
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> flag_q);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);
endmodule

// File: rtl/wdt_pulse.sv
// Module: wdt_pulse
// Produces a reset request of exactly PULSE_LEN cycles when fire_i is high.
// Assumes: fire_i cannot recur during a pulse, because the counter is held.
module wdt_pulse #(
    parameter int PULSE_LEN = 4,
    parameter int PCW       = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic req_o
);
    logic [PCW-1:0] left_q;

    // Load the length on a fire event and count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               left_q <= '0;
        else if (fire_i)          left_q <= PCW'(PULSE_LEN);
        else if (left_q != '0)    left_q <= left_q - 1'b1;
    end

    assign req_o = (left_q != '0);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= PCW'(PULSE_LEN));
    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(fire_i));
endmodule

// File: rtl/wdt_guard.sv
// Module: wdt_guard (top)
// Watchdog timer: counter, protected controls, sticky flag and a
// fixed-length reset request when the arm bit is set.
// Assumes: unlock_i comes from an external unlock sequence.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int EXP_BASE  = 17,
    parameter int EXP_STEP  = 3,
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ivl_sel_i,
    input  logic       kick_i,
    input  logic       arm_we_i,
    input  logic       arm_d_i,
    input  logic       unlock_i,
    input  logic       flag_clr_i,
    output logic       arm_o,
    output logic       expired_o,
    output logic       cpu_rst_o
);
    logic tick;
    logic restart;
    logic fire;

    wdt_counter #(.EXP_BASE(EXP_BASE), .EXP_STEP(EXP_STEP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sel_i(wdt_sel_t'(ivl_sel_i)),
        .restart_i(restart), .hold_i(cpu_rst_o), .tick_o(tick)
    );

    wdt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i), .kick_i(kick_i),
        .arm_we_i(arm_we_i), .arm_d_i(arm_d_i), .flag_clr_i(flag_clr_i),
        .tick_i(tick), .restart_o(restart), .arm_o(arm_o), .flag_o(expired_o)
    );

    // Request a reset only for a timeout while armed.
    always_comb fire = tick && arm_o;

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .req_o(cpu_rst_o)
    );

    // R7
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !arm_o && !cpu_rst_o) |=> !cpu_rst_o);
endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
    localparam int EB = 4;
    localparam int ES = 1;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ivl_sel_i = 2'd0;
    logic kick_i = 1'b0, arm_we_i = 1'b0, arm_d_i = 1'b0;
    logic unlock_i = 1'b0, flag_clr_i = 1'b0;
    logic arm_o, expired_o, cpu_rst_o;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdt_guard #(.EXP_BASE(EB), .EXP_STEP(ES), .PULSE_LEN(PL)) uut (
        .clk(clk), .rst_n(rst_n), .ivl_sel_i(ivl_sel_i), .kick_i(kick_i),
        .arm_we_i(arm_we_i), .arm_d_i(arm_d_i), .unlock_i(unlock_i),
        .flag_clr_i(flag_clr_i), .arm_o(arm_o), .expired_o(expired_o),
        .cpu_rst_o(cpu_rst_o)
    );

    function automatic int ivl(input int k);
        return 1 << (EB + k * ES);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply reset; return at the negedge where rst_n rises.
    task automatic do_reset();
        rst_n = 1'b0; ivl_sel_i = 2'd0; kick_i = 0; arm_we_i = 0;
        arm_d_i = 0; unlock_i = 0; flag_clr_i = 0;
        step(3);
        rst_n = 1'b1;
    endtask

    // R1: outputs cleared in and just after reset
    task automatic t_reset();
        do_reset();
        chk("R1 flag", expired_o, 0);
        chk("R1 rst", cpu_rst_o, 0);
        chk("R1 arm", arm_o, 0);
        step(1);
        chk("R1 flag after 1", expired_o, 0);
    endtask

    // R2/R3: default select times out after exactly one interval
    task automatic t_sel0();
        do_reset();
        step(ivl(0) - 1);
        chk("R2 sel0 before", expired_o, 0);
        step(1);
        chk("R2 sel0 at", expired_o, 1);
        chk("R7 disarmed no rst", cpu_rst_o, 0);
    endtask

    // R2/R9: other selects, timed from the change edge
    task automatic t_sel(input int k);
        do_reset();
        ivl_sel_i = 2'(k);
        step(ivl(k));
        chk("R2 R9 sel before", expired_o, 0);
        step(1);
        chk("R2 R9 sel at", expired_o, 1);
    endtask

    // R4: restart clears the count but not the flag
    task automatic t_kick();
        do_reset();
        step(10);
        unlock_i = 1; kick_i = 1; step(1); kick_i = 0;
        step(ivl(0) - 1);
        chk("R4 kick before", expired_o, 0);
        step(1);
        chk("R4 kick at", expired_o, 1);
        kick_i = 1; step(1); kick_i = 0;
        chk("R4 flag kept", expired_o, 1);
    endtask

    // R4: restart on the final cycle cancels the timeout
    task automatic t_kick_edge();
        do_reset();
        unlock_i = 1;
        step(ivl(0) - 1);
        kick_i = 1; step(1); kick_i = 0;
        chk("R4 edge cancel", expired_o, 0);
        step(ivl(0) - 1);
        chk("R4 edge before", expired_o, 0);
        step(1);
        chk("R4 edge later", expired_o, 1);
    endtask

    // R5: restart without permit is ignored
    task automatic t_kick_locked();
        do_reset();
        step(10);
        kick_i = 1; step(1); kick_i = 0;
        step(ivl(0) - 12);
        chk("R5 locked before", expired_o, 0);
        step(1);
        chk("R5 locked on time", expired_o, 1);
    endtask

    // R6: arm bit protected
    task automatic t_arm();
        do_reset();
        arm_we_i = 1; arm_d_i = 1; step(1);
        chk("R6 locked write", arm_o, 0);
        unlock_i = 1; step(1);
        chk("R6 permitted write", arm_o, 1);
        unlock_i = 0; arm_d_i = 0; step(1);
        chk("R6 locked clear", arm_o, 1);
        arm_we_i = 0; unlock_i = 1; step(1);
        chk("R6 no strobe", arm_o, 1);
    endtask

    // R7/R8: armed timeout gives a fixed pulse, then count restarts
    task automatic t_pulse();
        do_reset();
        unlock_i = 1; arm_we_i = 1; arm_d_i = 1; step(1);
        arm_we_i = 0; unlock_i = 0;
        step(ivl(0) - 2);
        chk("R7 before pulse", cpu_rst_o, 0);
        step(1);
        chk("R7 pulse start", cpu_rst_o, 1);
        step(PL - 1);
        chk("R7 pulse last", cpu_rst_o, 1);
        step(1);
        chk("R7 pulse end", cpu_rst_o, 0);
        step(ivl(0) - 1);
        chk("R8 before second", cpu_rst_o, 0);
        step(1);
        chk("R8 second pulse", cpu_rst_o, 1);
    endtask

    // R10/R3: clear works; a timeout on the same edge wins; flag wraps
    task automatic t_clear();
        do_reset();
        step(ivl(0));
        flag_clr_i = 1; step(1); flag_clr_i = 0;
        chk("R10 cleared", expired_o, 0);
        step(ivl(0) - 2);
        chk("R3 wrap before", expired_o, 0);
        flag_clr_i = 1; step(1); flag_clr_i = 0;
        chk("R10 set wins", expired_o, 1);
    endtask

    initial begin
        t_reset();
        t_sel0();
        for (int k = 1; k < 4; k++) t_sel(k);
        t_kick();
        t_kick_edge();
        t_kick_locked();
        t_arm();
        t_pulse();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule